// File: doc/BRIEF.md
# Delta-Sigma Conversion Start and Data-Ready Sequencer

This block decides when a delta-sigma converter starts to convert and when a result is flagged as ready. A conversion run can be requested from a dedicated start pin or from one-cycle start and stop pulses issued by a serial command decoder. The block divides the master clock into modulator ticks and counts a settling interval from the moment a run begins. It then drives an active-low data-ready output and a one-cycle latch strobe, once per output period in continuous mode or only once in single-shot mode.

The output period is 1024 modulator ticks shifted right by a 3-bit rate code. The first result after a start needs four periods plus four ticks to settle, and one more tick is added as margin. A step at the converter input during a continuous run needs three output periods, and the fourth ready pulse after the step is the first settled one. The filter itself is outside this block, but this delay is the reason for the four-period settling count. Data-ready falls with each result. It is released early by the first rising edge of the serial clock, which marks the start of a readback, or one tick before the next result otherwise.

Top module: `dsig_conv_seq`

## Requirements
- R1: When the start pin is low and no command-started run is active, `drdy_n` is high from the next clock on and `latch_stb` never pulses.
- R2: One modulator tick is D master clocks, with D = 4 when `clkdiv_sel` is 0 and D = 16 when it is 1.
- R3: A start (a rising start pin, or a `start_cmd` pulse with the pin low) drives `drdy_n` high on the next clock. `drdy_n` then first falls (4·P + 5)·D clocks after the start edge, where P = 1024 >> `rate_sel`.
- R4: In continuous mode (`single_shot` = 0) each later fall of `drdy_n` follows the previous one by exactly P·D clocks.
- R5: In single-shot mode (`single_shot` = 1) exactly one result is produced and no further strobe follows. Only a new rising edge of the start pin or a new `start_cmd` starts another conversion.
- R6: A `start_cmd` pulse sets a command run that lasts until `stop_cmd` or reset. A `start_cmd` that arrives while the pin is high is ignored, so the pin alone controls that run.
- R7: A rising edge on `sclk` while `drdy_n` is low drives `drdy_n` high on the next clock.
- R8: In continuous mode without readback, `drdy_n` returns high (P − 1)·D clocks after it fell, which is one tick before the next result.
- R9: `latch_stb` is a single-cycle pulse that is high exactly in the cycle in which `drdy_n` first reads low for a result.
- R10: `rate_sel` = 3'b111 is reserved. It sets `cfg_err` on the next clock and holds the block idle with `drdy_n` high. Once a valid code returns and a start source is still active, the sequence restarts from the settling count.
- R11: A `stop_cmd` pulse on a command-started run makes `drdy_n` high on the next clock and halts all later results.
- R12: The rate code and the divider select are captured at start, so changing them during a run leaves that run's period unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pin | input | 1 | Start pin level, runs while high |
| start_cmd | input | 1 | One-cycle start command pulse |
| stop_cmd | input | 1 | One-cycle stop command pulse |
| rate_sel | input | 3 | Output rate code, P = 1024 >> code, 111 reserved |
| clkdiv_sel | input | 1 | Tick divider select: 0 gives 4 clocks, 1 gives 16 clocks |
| single_shot | input | 1 | 1 = single-shot mode, 0 = continuous mode |
| sclk | input | 1 | Serial clock, synchronous to clk, a rising edge marks readback |
| drdy_n | output | 1 | Active-low data ready |
| latch_stb | output | 1 | One-cycle strobe to capture a new result |
| cfg_err | output | 1 | Reserved rate code selected |

## Verification
Several properties are checked on every cycle: the halt behaviour when no start source is active, the release of data-ready right after a rising start pin, the strobe being a single pulse that coincides with every data-ready fall, and the reserved-code flag together with its idle output. The actual lengths of the settling and period intervals, the early release before the next result, and the single-shot stop and restart can only be shown by the bench scenarios. These scenarios measure clock counts between output edges for several rate and divider settings and compare them with the formulas.

// File: rtl/dsig_conv_seq_pkg.sv
package dsig_conv_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETTLE = 2'd1,
        SEQ_RUN    = 2'd2,
        SEQ_HOLD   = 2'd3
    } seq_state_e;

    // Ticks added after the four settling periods, plus one tick of margin
    localparam int SETTLE_PAD_TICKS  = 4;
    localparam int SETTLE_MARGIN     = 1;
    localparam int SETTLE_PERIODS    = 4;

endpackage

// File: rtl/dsig_tick_div.sv
module dsig_tick_div #(
    parameter int FAST_DIV = 4,
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic slow,
    output logic tick
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int DIV_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_regs_t;

    div_regs_t        r_d, r_q;
    logic [DIV_W-1:0] wrap_at;

    always_comb begin
        wrap_at = slow ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
        tick    = en && !clr && (r_q.cnt == wrap_at);
        r_d     = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (en) begin
            r_d.cnt = tick ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/dsig_interval_cnt.sv
module dsig_interval_cnt #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] target,
    output logic             last,
    output logic             near_end
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_regs_t;

    ivl_regs_t r_d, r_q;

    always_comb begin
        last     = tick && (r_q.cnt == target - 1'b1);
        near_end = tick && (r_q.cnt == target - CNT_W'(2));
        r_d      = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (tick) begin
            r_d.cnt = last ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/dsig_start_ctrl.sv
module dsig_start_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pin,
    input  logic start_cmd,
    input  logic stop_cmd,
    output logic run_now,
    output logic restart,
    output logic cmd_run
);
    typedef struct packed {
        logic cmd_run;
        logic pin;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic      cmd_accept;

    always_comb begin
        // The pin has priority: a command that arrives while the pin is high is dropped
        cmd_accept = start_cmd && !start_pin && !stop_cmd;
        r_d        = r_q;
        r_d.pin    = start_pin;
        if (stop_cmd)        r_d.cmd_run = 1'b0;
        else if (cmd_accept) r_d.cmd_run = 1'b1;
        run_now = start_pin || r_d.cmd_run;
        restart = (start_pin && !r_q.pin) || cmd_accept;
        cmd_run = r_q.cmd_run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/dsig_conv_seq.sv
module dsig_conv_seq
    import dsig_conv_seq_pkg::*;
#(
    parameter int RATE_W      = 3,
    parameter int BASE_PERIOD = 1024,
    parameter int FAST_DIV    = 4,
    parameter int SLOW_DIV    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pin,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              clkdiv_sel,
    input  logic              single_shot,
    input  logic              sclk,
    output logic              drdy_n,
    output logic              latch_stb,
    output logic              cfg_err
);
    localparam int MAX_SETTLE = SETTLE_PERIODS * BASE_PERIOD + SETTLE_PAD_TICKS + SETTLE_MARGIN;
    localparam int CNT_W      = $clog2(MAX_SETTLE + 1);
    localparam logic [RATE_W-1:0] RATE_RSVD = '1;

    typedef struct packed {
        seq_state_e        st;
        logic              drdy_n;
        logic              stb;
        logic              err;
        logic [RATE_W-1:0] rate;
        logic              slow;
        logic              sclk;
    } seq_regs_t;

    seq_regs_t        r_d, r_q;
    logic             run_now, restart, cmd_run;
    logic             tick, last, near_end;
    logic             clr, counting, rsvd, sclk_rise;
    logic [CNT_W-1:0] target;

    function automatic logic [CNT_W-1:0] period_ticks(input logic [RATE_W-1:0] code);
        return CNT_W'(BASE_PERIOD >> code);
    endfunction

    function automatic logic [CNT_W-1:0] settle_ticks(input logic [RATE_W-1:0] code);
        return CNT_W'(SETTLE_PERIODS * (BASE_PERIOD >> code) + SETTLE_PAD_TICKS + SETTLE_MARGIN);
    endfunction

    dsig_start_ctrl u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pin (start_pin),
        .start_cmd (start_cmd),
        .stop_cmd  (stop_cmd),
        .run_now   (run_now),
        .restart   (restart),
        .cmd_run   (cmd_run)
    );

    dsig_tick_div #(
        .FAST_DIV (FAST_DIV),
        .SLOW_DIV (SLOW_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (counting),
        .slow  (r_q.slow),
        .tick  (tick)
    );

    dsig_interval_cnt #(
        .CNT_W (CNT_W)
    ) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick),
        .target   (target),
        .last     (last),
        .near_end (near_end)
    );

    always_comb begin
        counting  = (r_q.st == SEQ_SETTLE) || (r_q.st == SEQ_RUN);
        target    = (r_q.st == SEQ_SETTLE) ? settle_ticks(r_q.rate) : period_ticks(r_q.rate);
        rsvd      = (rate_sel == RATE_RSVD);
        sclk_rise = sclk && !r_q.sclk;
        clr       = 1'b0;

        r_d      = r_q;
        r_d.stb  = 1'b0;
        r_d.sclk = sclk;
        r_d.err  = rsvd;

        if (rsvd || !run_now) begin
            r_d.st     = SEQ_IDLE;
            r_d.drdy_n = 1'b1;
        end else if (restart || r_q.st == SEQ_IDLE) begin
            r_d.st     = SEQ_SETTLE;
            r_d.drdy_n = 1'b1;
            r_d.rate   = rate_sel;
            r_d.slow   = clkdiv_sel;
            clr        = 1'b1;
        end else begin
            unique case (r_q.st)
                SEQ_SETTLE, SEQ_RUN: begin
                    if (last) begin
                        r_d.drdy_n = 1'b0;
                        r_d.stb    = 1'b1;
                        r_d.st     = single_shot ? SEQ_HOLD : SEQ_RUN;
                    end else if (sclk_rise || (near_end && r_q.st == SEQ_RUN)) begin
                        r_d.drdy_n = 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (sclk_rise) r_d.drdy_n = 1'b1;
                end
                default: begin
                    r_d.st = SEQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= SEQ_IDLE;
            r_q.drdy_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign drdy_n    = r_q.drdy_n;
    assign latch_stb = r_q.stb;
    assign cfg_err   = r_q.err;

endmodule

// File: rtl/dsig_conv_seq_chk.sv
module dsig_conv_seq_chk #(
    parameter int RATE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_pin,
    input logic              start_cmd,
    input logic [RATE_W-1:0] rate_sel,
    input logic              cmd_run,
    input logic              drdy_n,
    input logic              latch_stb,
    input logic              cfg_err
);

    AST_HALT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_pin && !cmd_run && !start_cmd) |=> (drdy_n && !latch_stb)); // R1

    AST_PIN_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_pin) |=> drdy_n); // R3

    AST_STB_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |-> !drdy_n); // R9

    AST_FALL_HAS_STB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drdy_n) |-> latch_stb); // R9

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_stb |=> !latch_stb); // R9

    AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel == '1) |=> cfg_err); // R10

    AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (drdy_n && !latch_stb)); // R10

endmodule

bind dsig_conv_seq dsig_conv_seq_chk #(.RATE_W(RATE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_pin (start_pin),
    .start_cmd (start_cmd),
    .rate_sel  (rate_sel),
    .cmd_run   (cmd_run),
    .drdy_n    (drdy_n),
    .latch_stb (latch_stb),
    .cfg_err   (cfg_err)
);

// File: tb/dsig_conv_seq_tb.sv
module dsig_conv_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_pin = 1'b0;
    logic       start_cmd = 1'b0;
    logic       stop_cmd = 1'b0;
    logic [2:0] rate_sel = 3'd6;
    logic       clkdiv_sel = 1'b0;
    logic       single_shot = 1'b0;
    logic       sclk = 1'b0;
    logic       drdy_n, latch_stb, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dsig_conv_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pin   (start_pin),
        .start_cmd   (start_cmd),
        .stop_cmd    (stop_cmd),
        .rate_sel    (rate_sel),
        .clkdiv_sel  (clkdiv_sel),
        .single_shot (single_shot),
        .sclk        (sclk),
        .drdy_n      (drdy_n),
        .latch_stb   (latch_stb),
        .cfg_err     (cfg_err)
    );

    function automatic int div_of(input logic dv);
        return dv ? 16 : 4;
    endfunction

    function automatic int per_clks(input int r, input logic dv);
        return (1024 >> r) * div_of(dv);
    endfunction

    function automatic int settle_clks(input int r, input logic dv);
        return (4 * (1024 >> r) + 5) * div_of(dv);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts rising clock edges until drdy_n is seen going 1 -> 0 at a falling edge
    task automatic wait_fall(input int lim, output int n, output logic stb_seen);
        logic prev = drdy_n;
        n = 0;
        stb_seen = 1'b0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (prev && !drdy_n) begin
                stb_seen = latch_stb;
                break;
            end
            prev = drdy_n;
            if (n >= lim) begin
                n = -1;
                break;
            end
        end
    endtask

    task automatic wait_high(input int lim, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (drdy_n) break;
            if (n >= lim) begin
                n = -1;
                break;
            end
        end
    endtask

    task automatic quiet(input int cyc, output int bad);
        bad = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (!drdy_n || latch_stb) bad++;
        end
    endtask

    task automatic pulse_sclk();
        sclk = 1'b1;
        @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic pulse_start();
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R1 watchdog actual=190000 expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int   n, bad;
        logic stb;
        void'($urandom(32'd20517));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drdy_n && !latch_stb && !cfg_err, "R1 reset state", int'(drdy_n), 1);
        quiet(1500, bad);
        check(bad == 0, "R1 idle without start", bad, 0);

        // Pin start, rate 6, divide by 4
        rate_sel = 3'd6; clkdiv_sel = 1'b0; single_shot = 1'b0;
        start_pin = 1'b1;
        @(posedge clk); @(negedge clk);
        check(drdy_n == 1'b1, "R3 released after start", int'(drdy_n), 1);
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0), "R3 settle count", n + 1, settle_clks(6, 1'b0) + 1);
        check(stb == 1'b1, "R9 strobe at fall", int'(stb), 1);
        @(negedge clk);
        check(latch_stb == 1'b0, "R9 strobe single cycle", int'(latch_stb), 0);
        wait_high(5000, n);
        check(n == per_clks(6, 1'b0) - 4 - 1, "R8 early release", n + 1, per_clks(6, 1'b0) - 4);
        wait_fall(5000, n, stb);
        check(n == 4, "R4 period after release", n, 4);
        wait_fall(5000, n, stb);
        check(n == per_clks(6, 1'b0), "R4 continuous period", n, per_clks(6, 1'b0));

        // Readback release
        repeat (10) @(negedge clk);
        pulse_sclk();
        check(drdy_n == 1'b1, "R7 sclk release", int'(drdy_n), 1);

        // R12: rate change mid-run keeps the period
        wait_fall(5000, n, stb);
        rate_sel = 3'd4; clkdiv_sel = 1'b1;
        wait_fall(5000, n, stb);
        check(n == per_clks(6, 1'b0), "R12 captured rate", n, per_clks(6, 1'b0));

        // R1: pin low halts
        start_pin = 1'b0;
        @(negedge clk);
        check(drdy_n == 1'b1, "R1 halt on pin low", int'(drdy_n), 1);
        quiet(800, bad);
        check(bad == 0, "R1 halted stays quiet", bad, 0);

        // R2: divide by 16, rate 5
        rate_sel = 3'd5; clkdiv_sel = 1'b1;
        start_pin = 1'b1;
        wait_fall(40000, n, stb);
        check(n == settle_clks(5, 1'b1) + 1, "R2 slow divider settle", n, settle_clks(5, 1'b1) + 1);
        wait_fall(40000, n, stb);
        check(n == per_clks(5, 1'b1), "R2 slow divider period", n, per_clks(5, 1'b1));
        start_pin = 1'b0;
        @(negedge clk);

        // R5: single shot from pin
        rate_sel = 3'd6; clkdiv_sel = 1'b0; single_shot = 1'b1;
        start_pin = 1'b1;
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0) + 1, "R5 single shot settle", n, settle_clks(6, 1'b0) + 1);
        repeat (300) @(negedge clk);
        check(drdy_n == 1'b0, "R5 held until readback", int'(drdy_n), 0);
        pulse_sclk();
        check(drdy_n == 1'b1, "R7 release in hold", int'(drdy_n), 1);
        quiet(600, bad);
        check(bad == 0, "R5 no second result", bad, 0);
        start_pin = 1'b0;
        @(negedge clk);

        // R5/R6: command start in single shot, then command restart
        pulse_start();
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0), "R6 command start settle", n, settle_clks(6, 1'b0));
        pulse_sclk();
        quiet(400, bad);
        check(bad == 0, "R5 command single shot stops", bad, 0);
        pulse_start();
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0), "R5 command restart", n, settle_clks(6, 1'b0));
        pulse_sclk();

        // R11: stop command halts a continuous command run
        single_shot = 1'b0;
        pulse_start();
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0), "R6 continuous command run", n, settle_clks(6, 1'b0));
        pulse_stop();
        check(drdy_n == 1'b1, "R11 stop releases", int'(drdy_n), 1);
        quiet(800, bad);
        check(bad == 0, "R11 stopped quiet", bad, 0);

        // R6: command while pin high is ignored
        start_pin = 1'b1;
        repeat (20) @(negedge clk);
        pulse_start();
        start_pin = 1'b0;
        @(negedge clk);
        quiet(800, bad);
        check(bad == 0, "R6 command ignored under pin", bad, 0);

        // R10: reserved code
        start_pin = 1'b1;
        wait_fall(20000, n, stb);
        rate_sel = 3'd7;
        @(negedge clk);
        check(cfg_err == 1'b1 && drdy_n == 1'b1, "R10 reserved flag", int'(cfg_err), 1);
        quiet(700, bad);
        check(bad == 0, "R10 reserved idle", bad, 0);
        rate_sel = 3'd6;
        wait_fall(20000, n, stb);
        check(n == settle_clks(6, 1'b0) + 1, "R10 restart after valid code", n, settle_clks(6, 1'b0) + 1);
        check(cfg_err == 1'b0, "R10 flag clears", int'(cfg_err), 0);
        start_pin = 1'b0;
        @(negedge clk);

        // Random rates and dividers, continuous mode
        for (int i = 0; i < 6; i++) begin
            int   r;
            logic dv;
            r  = 4 + int'($urandom_range(2));
            dv = logic'($urandom_range(1));
            rate_sel = 3'(r); clkdiv_sel = dv;
            start_pin = 1'b1;
            wait_fall(40000, n, stb);
            check(n == settle_clks(r, dv) + 1, "R3 random settle", n, settle_clks(r, dv) + 1);
            wait_fall(40000, n, stb);
            check(n == per_clks(r, dv), "R4 random period", n, per_clks(r, dv));
            start_pin = 1'b0;
            repeat (3) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule